// File: doc/BRIEF.md
# Power-Up and Reset Sequencer for an External Device

This controller brings an external peripheral out of the unpowered state. The peripheral has an I/O supply and a group of core supplies, an active-low power-down line and an active-low reset line. In the ordered mode the controller switches on the I/O rail and waits for its power-good input. It then switches on the core group and waits for that power-good input. Next it releases power-down, waits a timed interval and releases reset. After a second timed interval it raises a ready flag, and only then may serial configuration traffic start.

In the simplified mode every rail and both control lines come up in the same cycle. The controller then asks for a software reset and holds the request until the requester acknowledges it while both rails report good. A longer wait follows before ready is raised. A power-down request clears ready in the same cycle and switches everything off. A power-good input that drops, or one that does not arrive within a bounded time, sends the controller into a latched fault state. In that state everything is held off until the next start request.

All delays come from one shared down-counter. Millisecond waits are given as a count of milliseconds times `CLKS_PER_MS` clock cycles. Power-good inputs pass through two-flop synchronizers.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every output is 0: `io_en_o`, `core_en_o`, `dev_pd_n_o`, `dev_rst_n_o`, `swrst_req_o`, `ready_o`, `fault_o`.
- R2: In ordered mode (`simple_mode_i`=0), `start_i` raises `io_en_o` one edge later while both device lines stay low. `core_en_o` rises on the third rising edge after `io_pg_i` goes high (two synchronizer flops, then the state change), never earlier, and never without `io_en_o`.
- R3: In ordered mode, `dev_pd_n_o` rises on the third rising edge after `core_pg_i` goes high while the core group is enabled.
- R4: In ordered mode, `dev_rst_n_o` rises exactly `PD_WAIT_MS*CLKS_PER_MS` cycles after `dev_pd_n_o`, and never while `dev_pd_n_o` is low.
- R5: In ordered mode, `ready_o` rises exactly `RDY_WAIT_MS*CLKS_PER_MS` cycles after `dev_rst_n_o`. `ready_o` is only ever high with both rails enabled and both device lines high.
- R6: In simplified mode, `start_i` raises `io_en_o`, `core_en_o`, `dev_pd_n_o`, `dev_rst_n_o` and `swrst_req_o` on the same edge. `swrst_req_o` stays high until an edge sees `swrst_ack_i` high with both synchronized power-good inputs high. `ready_o` rises exactly `SIM_WAIT_MS*CLKS_PER_MS` cycles after `swrst_req_o` falls.
- R7: `pdown_req_i` high in any sequencing or ready state forces `ready_o` low in the same cycle. On the next edge it drops every enable and both device lines. The edge after that returns the controller to idle.
- R8: If the awaited power-good (or, in simplified mode, acknowledge with power-good) is missing for `PG_TIMEOUT` cycles after a wait state is entered, the controller enters fault: `fault_o`=1 and every other output 0.
- R9: A power-good input of an already confirmed rail going low raises `fault_o` on the third rising edge after the drop.
- R10: `fault_o` stays high until `start_i` arrives with `pdown_req_i` low. That start clears `fault_o` and begins a new sequence in the mode given by `simple_mode_i`. `start_i` has no effect in any other non-idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high controller reset |
| start_i | input | 1 | Request to begin a bring-up sequence |
| simple_mode_i | input | 1 | 1 selects simultaneous bring-up, 0 the ordered one |
| pdown_req_i | input | 1 | Request to remove all supplies |
| io_pg_i | input | 1 | Power-good of the I/O rail (asynchronous) |
| core_pg_i | input | 1 | Power-good of the core supply group (asynchronous) |
| swrst_ack_i | input | 1 | Acknowledge of the software-reset request |
| io_en_o | output | 1 | Enable of the I/O rail |
| core_en_o | output | 1 | Enable of the core supply group |
| dev_pd_n_o | output | 1 | Active-low power-down line to the device |
| dev_rst_n_o | output | 1 | Active-low reset line to the device |
| swrst_req_o | output | 1 | Software-reset request (simplified mode) |
| ready_o | output | 1 | Device may now be configured |
| fault_o | output | 1 | Latched rail fault |

## Verification
A wrong state register shows up at the enable and device-line outputs on the very next edge, because every output is decoded from the state. The bench's cycle model compares all seven outputs on every clock, so a stray transition is reported within one cycle. A timer that loads the wrong value moves a device-line edge or the ready edge. The bench catches this through measured intervals of 20, 20 and 40 cycles. A missing synchronizer stage moves the rail-gated edges from the third rising edge to the second, and the per-cycle comparison flags that at once.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int RAIL_CNT = 2;
    localparam int RAIL_IO   = 0;
    localparam int RAIL_CORE = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IO_UP,
        ST_CORE_UP,
        ST_PD_REL,
        ST_RST_REL,
        ST_READY,
        ST_SIM_ON,
        ST_SIM_WAIT,
        ST_PWR_OFF,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic io_en;
        logic core_en;
        logic pd_n;
        logic rst_n;
        logic swrst_req;
        logic fault;
    } rail_ctl_t;

    function automatic rail_ctl_t ctl_of(seq_state_e s);
        rail_ctl_t c;
        c = '0;
        case (s)
            ST_IO_UP:   c.io_en = 1'b1;
            ST_CORE_UP: begin
                c.io_en   = 1'b1;
                c.core_en = 1'b1;
            end
            ST_PD_REL: begin
                c.io_en   = 1'b1;
                c.core_en = 1'b1;
                c.pd_n    = 1'b1;
            end
            ST_RST_REL, ST_READY, ST_SIM_WAIT: begin
                c.io_en   = 1'b1;
                c.core_en = 1'b1;
                c.pd_n    = 1'b1;
                c.rst_n   = 1'b1;
            end
            ST_SIM_ON: begin
                c.io_en     = 1'b1;
                c.core_en   = 1'b1;
                c.pd_n      = 1'b1;
                c.rst_n     = 1'b1;
                c.swrst_req = 1'b1;
            end
            ST_FAULT:   c.fault = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_active(seq_state_e s);
        return (s inside {ST_IO_UP, ST_CORE_UP, ST_PD_REL, ST_RST_REL,
                          ST_READY, ST_SIM_ON, ST_SIM_WAIT});
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stg;
        always_ff @(posedge clk) begin
            if (rst) stg <= 2'b00;
            else     stg <= {stg[0], d[i]};
        end
        assign q[i] = stg[1];
    end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R4: an idle counter rests at zero, a running one steps down by one
    p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));
    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int unsigned CLKS_PER_MS = 50000,
    parameter int unsigned PG_TIMEOUT  = 1000,
    parameter int unsigned PD_WAIT_MS  = 5,
    parameter int unsigned RDY_WAIT_MS = 5,
    parameter int unsigned SIM_WAIT_MS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic simple_mode_i,
    input  logic pdown_req_i,
    input  logic io_pg_i,
    input  logic core_pg_i,
    input  logic swrst_ack_i,
    output logic io_en_o,
    output logic core_en_o,
    output logic dev_pd_n_o,
    output logic dev_rst_n_o,
    output logic swrst_req_o,
    output logic ready_o,
    output logic fault_o
);
    localparam int unsigned PD_CYC  = PD_WAIT_MS  * CLKS_PER_MS;
    localparam int unsigned RDY_CYC = RDY_WAIT_MS * CLKS_PER_MS;
    localparam int unsigned SIM_CYC = SIM_WAIT_MS * CLKS_PER_MS;
    localparam int unsigned MAX_A   = (PD_CYC > RDY_CYC) ? PD_CYC : RDY_CYC;
    localparam int unsigned MAX_B   = (SIM_CYC > PG_TIMEOUT) ? SIM_CYC : PG_TIMEOUT;
    localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int          CW      = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] LD_PG  = CW'(PG_TIMEOUT - 1);
    localparam logic [CW-1:0] LD_PD  = CW'(PD_CYC - 1);
    localparam logic [CW-1:0] LD_RDY = CW'(RDY_CYC - 1);
    localparam logic [CW-1:0] LD_SIM = CW'(SIM_CYC - 1);

    seq_state_e           state_q, state_n;
    logic [RAIL_CNT-1:0]  pg_s;
    logic                 io_ok, core_ok, both_ok;
    logic                 tmr_load, tmr_done;
    logic [CW-1:0]        tmr_val;
    rail_ctl_t            ctl;

    pwrseq_sync #(.W(RAIL_CNT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({core_pg_i, io_pg_i}),
        .q   (pg_s)
    );

    assign io_ok   = pg_s[RAIL_IO];
    assign core_ok = pg_s[RAIL_CORE];
    assign both_ok = io_ok && core_ok;

    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_IDLE, ST_FAULT:
                if (start_i && !pdown_req_i)
                    state_n = simple_mode_i ? ST_SIM_ON : ST_IO_UP;
            ST_IO_UP:
                if (io_ok)          state_n = ST_CORE_UP;
                else if (tmr_done)  state_n = ST_FAULT;
            ST_CORE_UP:
                if (!io_ok)         state_n = ST_FAULT;
                else if (core_ok)   state_n = ST_PD_REL;
                else if (tmr_done)  state_n = ST_FAULT;
            ST_PD_REL:
                if (!both_ok)       state_n = ST_FAULT;
                else if (tmr_done)  state_n = ST_RST_REL;
            ST_RST_REL:
                if (!both_ok)       state_n = ST_FAULT;
                else if (tmr_done)  state_n = ST_READY;
            ST_READY:
                if (!both_ok)       state_n = ST_FAULT;
            ST_SIM_ON:
                if (swrst_ack_i && both_ok) state_n = ST_SIM_WAIT;
                else if (tmr_done)          state_n = ST_FAULT;
            ST_SIM_WAIT:
                if (!both_ok)       state_n = ST_FAULT;
                else if (tmr_done)  state_n = ST_READY;
            ST_PWR_OFF:             state_n = ST_IDLE;
            default:                state_n = ST_IDLE;
        endcase
        if (is_active(state_q) && pdown_req_i)
            state_n = ST_PWR_OFF;
    end

    always_comb begin
        case (state_n)
            ST_IO_UP, ST_CORE_UP, ST_SIM_ON: tmr_val = LD_PG;
            ST_PD_REL:                       tmr_val = LD_PD;
            ST_RST_REL:                      tmr_val = LD_RDY;
            ST_SIM_WAIT:                     tmr_val = LD_SIM;
            default:                         tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_n != state_q);

    pwrseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    assign ctl         = ctl_of(state_q);
    assign io_en_o     = ctl.io_en;
    assign core_en_o   = ctl.core_en;
    assign dev_pd_n_o  = ctl.pd_n;
    assign dev_rst_n_o = ctl.rst_n;
    assign swrst_req_o = ctl.swrst_req;
    assign fault_o     = ctl.fault;
    assign ready_o     = (state_q == ST_READY) && !pdown_req_i;

    // R2: core group never on without the I/O rail, and in ordered mode only after I/O power-good
    p_core_needs_io_r2: assert property (@(posedge clk) disable iff (rst)
        core_en_o |-> io_en_o);
    p_core_gated_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(core_en_o) |-> ($past(io_ok) || $rose(io_en_o)));
    // R4: reset line never released before power-down line
    p_rst_after_pd_r4: assert property (@(posedge clk) disable iff (rst)
        dev_rst_n_o |-> dev_pd_n_o);
    // R5: ready only with full power and both lines released
    p_ready_full_r5: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (io_en_o && core_en_o && dev_pd_n_o && dev_rst_n_o));
    // R7: a power-down request removes the rails on the next edge
    p_pdown_off_r7: assert property (@(posedge clk) disable iff (rst)
        (pdown_req_i && io_en_o) |=> (!io_en_o && !core_en_o && !dev_pd_n_o && !dev_rst_n_o));
    // R8: fault keeps everything off
    p_fault_off_r8: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (!io_en_o && !core_en_o && !dev_pd_n_o && !dev_rst_n_o && !ready_o));
endmodule

// File: tb/sim_pwrseq_ctrl.sv
module sim_pwrseq_ctrl;
    localparam int CPM = 4;
    localparam int TO  = 8;
    localparam int PD  = 5 * CPM;
    localparam int RD  = 5 * CPM;
    localparam int SW  = 10 * CPM;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, simple = 1'b0, pdown = 1'b0;
    logic io_pg = 1'b0, core_pg = 1'b0, ack = 1'b0;
    logic io_en, core_en, pd_n, rst_n, swrq, ready, fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwrseq_ctrl #(.CLKS_PER_MS(CPM), .PG_TIMEOUT(TO)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .simple_mode_i(simple),
        .pdown_req_i(pdown), .io_pg_i(io_pg), .core_pg_i(core_pg),
        .swrst_ack_i(ack), .io_en_o(io_en), .core_en_o(core_en),
        .dev_pd_n_o(pd_n), .dev_rst_n_o(rst_n), .swrst_req_o(swrq),
        .ready_o(ready), .fault_o(fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: codes 0 idle,1 io,2 core,3 pd,4 rst,5 ready,6 simon,7 simwait,8 off,9 fault
    int m_st = 0, m_cnt = 0;
    bit m_q1io = 0, m_sio = 0, m_q1co = 0, m_sco = 0;

    always @(posedge clk) begin
        int nxt;
        bit act;
        cyc++;
        #1;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_q1io = 0; m_sio = 0; m_q1co = 0; m_sco = 0;
        end else begin
            nxt = m_st;
            act = (m_st >= 1 && m_st <= 7);
            if (m_st == 0 || m_st == 9) begin
                if (start && !pdown) nxt = simple ? 6 : 1;
            end else if (m_st == 1) begin
                if (m_sio) nxt = 2; else if (m_cnt == TO-1) nxt = 9;
            end else if (m_st == 2) begin
                if (!m_sio) nxt = 9; else if (m_sco) nxt = 3; else if (m_cnt == TO-1) nxt = 9;
            end else if (m_st == 3) begin
                if (!(m_sio && m_sco)) nxt = 9; else if (m_cnt == PD-1) nxt = 4;
            end else if (m_st == 4) begin
                if (!(m_sio && m_sco)) nxt = 9; else if (m_cnt == RD-1) nxt = 5;
            end else if (m_st == 5) begin
                if (!(m_sio && m_sco)) nxt = 9;
            end else if (m_st == 6) begin
                if (ack && m_sio && m_sco) nxt = 7; else if (m_cnt == TO-1) nxt = 9;
            end else if (m_st == 7) begin
                if (!(m_sio && m_sco)) nxt = 9; else if (m_cnt == SW-1) nxt = 5;
            end else begin
                nxt = 0;
            end
            if (act && pdown) nxt = 8;
            m_cnt = (nxt != m_st) ? 0 : m_cnt + 1;
            m_st  = nxt;
            m_sio = m_q1io; m_q1io = io_pg;
            m_sco = m_q1co; m_q1co = core_pg;
        end
    end

    // per-cycle comparison, mid-cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 io_en",   int'(io_en),   int'(m_st >= 1 && m_st <= 7));
            chk("R2 core_en", int'(core_en), int'(m_st >= 2 && m_st <= 7));
            chk("R3 pd_n",    int'(pd_n),    int'(m_st >= 3 && m_st <= 7));
            chk("R4 rst_n",   int'(rst_n),   int'(m_st >= 4 && m_st <= 7 && m_st != 3));
            chk("R6 swrst",   int'(swrq),    int'(m_st == 6));
            chk("R5 ready",   int'(ready),   int'(m_st == 5 && !pdown));
            chk("R8 fault",   int'(fault),   int'(m_st == 9));
        end
    end

    // edge-time recorder for interval checks
    int t_pd = 0, t_rst = 0, t_rdy = 0, t_swf = 0;
    logic p_pd = 0, p_rst = 0, p_rdy = 0, p_sw = 0;
    always @(negedge clk) begin
        if (pd_n && !p_pd)   t_pd  = cyc;
        if (rst_n && !p_rst) t_rst = cyc;
        if (ready && !p_rdy) t_rdy = cyc;
        if (!swrq && p_sw)   t_swf = cyc;
        p_pd = pd_n; p_rst = rst_n; p_rdy = ready; p_sw = swrq;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        chk("R1 outputs in reset", int'({io_en, core_en, pd_n, rst_n, swrq, ready, fault}), 0);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1 outputs after reset", int'({io_en, core_en, pd_n, rst_n, swrq, ready, fault}), 0);

        // ordered bring-up
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        chk("R2 io rail first", int'(io_en), 1);
        chk("R2 lines held low", int'({core_en, pd_n, rst_n}), 0);
        wait_cyc(3);
        io_pg = 1'b1;
        wait_cyc(2);
        chk("R2 core not before sync", int'(core_en), 0);
        wait_cyc(1);
        chk("R2 core after io good", int'(core_en), 1);
        wait_cyc(2);
        core_pg = 1'b1;
        wait_cyc(3);
        chk("R3 power-down released", int'(pd_n), 1);
        wait_cyc(50);
        chk("R4 pd to reset interval", t_rst - t_pd, PD);
        chk("R5 reset to ready interval", t_rdy - t_rst, RD);
        chk("R5 ready high", int'(ready), 1);
        start = 1'b1;
        wait_cyc(2);
        start = 1'b0;
        chk("R10 start ignored in ready", int'(ready), 1);

        // power-down
        pdown = 1'b1;
        #1;
        chk("R7 ready drops same cycle", int'(ready), 0);
        wait_cyc(1);
        chk("R7 rails off", int'({io_en, core_en, pd_n, rst_n}), 0);
        pdown = 1'b0;
        io_pg = 1'b0;
        core_pg = 1'b0;
        wait_cyc(3);

        // timeout on missing I/O power-good
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        wait_cyc(12);
        chk("R8 timeout fault", int'(fault), 1);
        chk("R8 io rail dropped", int'(io_en), 0);
        wait_cyc(5);
        chk("R10 fault latched", int'(fault), 1);

        // simplified bring-up from fault
        simple = 1'b1;
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        chk("R6 all up together", int'({io_en, core_en, pd_n, rst_n, swrq}), 31);
        chk("R10 start clears fault", int'(fault), 0);
        io_pg = 1'b1;
        core_pg = 1'b1;
        ack = 1'b1;
        wait_cyc(4);
        ack = 1'b0;
        chk("R6 request withdrawn", int'(swrq), 0);
        wait_cyc(50);
        chk("R6 request to ready interval", t_rdy - t_swf, SW);
        chk("R6 ready high", int'(ready), 1);

        // rail drop in ready
        core_pg = 1'b0;
        wait_cyc(2);
        chk("R9 no fault before sync", int'(fault), 0);
        wait_cyc(1);
        chk("R9 fault after drop", int'(fault), 1);

        // start blocked by power-down request
        pdown = 1'b1;
        start = 1'b1;
        wait_cyc(2);
        chk("R10 start blocked by pdown", int'(fault), 1);
        start = 1'b0;
        pdown = 1'b0;
        wait_cyc(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule